// File: doc/BRIEF.md
# Stack Push/Pull Instruction Unit

This block runs the one-byte stack transfer instructions of a small 8-bit accumulator processor. It holds the accumulator, the two index registers, the flag byte, the stack pointer and the program counter. Each instruction moves one register to or from the stack in memory page 1.

A fetch stage presents an opcode together with a one-cycle `start` strobe while the unit is idle. For a push, the unit writes the named register to the stack through a synchronous byte-wide memory port and then moves the stack pointer down. For a pull, it moves the stack pointer up, reads the byte and loads it into the named register. A pull into a data register also updates the zero and negative flags. A pull into the flag register forces three flag bits to one.

The unit marks the last cycle of each instruction with `done` and advances the program counter by one at that point. An opcode it does not execute produces a one-cycle `unhandled` pulse and changes nothing. Before a program runs, all registers can be loaded through a preload port.

Top module: `stack_xfer_unit`

## Requirements
- R1: After reset the stack pointer is 0xFF. The accumulator, X, Y, the flag byte and the PC are zero. `busy`, `done`, `unhandled` and `memWe` are low.
- R2: Opcode 0x48 pushes the accumulator, 0x08 the flags, 0xDA X and 0x5A Y. The byte is written once, with `memWe` high, to address 0x0100 + SP, and SP is then decremented.
- R3: A push accepted at a clock edge keeps `busy` high for three cycles, and `done` is high in the third of them.
- R4: Opcode 0x68 pulls into the accumulator, 0x28 into the flags, 0xFA into X and 0x7A into Y. SP is incremented first, and the byte is then read from 0x0100 + new SP. Read data returns one cycle after the address.
- R5: A pull accepted at a clock edge keeps `busy` high for four cycles, and `done` is high in the fourth of them.
- R6: A pull into A, X or Y sets flag bit 1 (zero) exactly when the byte is 0x00 and copies byte bit 7 into flag bit 7 (negative). Every other flag bit keeps its value.
- R7: A pull into the flags loads the byte with bits 2, 4 and 5 forced to one (byte OR 0x34).
- R8: Pushing the flags stores the flag byte unchanged, and no push alters any flag bit.
- R9: Every push or pull adds exactly one to the PC. Registers the instruction does not name keep their values.
- R10: SP wraps modulo 256. A push with SP = 0x00 writes 0x0100 and leaves SP at 0xFF. A pull with SP = 0xFF reads 0x0100 and leaves SP at 0x00.
- R11: Any other opcode raises `unhandled` for the one cycle after `start`. It does not set `busy` and leaves every register and the PC unchanged.
- R12: A `start` strobe that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| preloadEn | input | 1 | Loads all registers from the preload inputs (use only while idle) |
| preloadA | input | 8 | Accumulator preload value |
| preloadX | input | 8 | X preload value |
| preloadY | input | 8 | Y preload value |
| preloadF | input | 8 | Flag byte preload value |
| preloadSp | input | 8 | Stack pointer preload value |
| preloadPc | input | 16 | Program counter preload value |
| start | input | 1 | Opcode valid strobe, taken only while idle |
| opcode | input | 8 | Instruction opcode |
| busy | output | 1 | An instruction is executing |
| done | output | 1 | Last cycle of the executing instruction |
| unhandled | output | 1 | One-cycle pulse for an opcode this unit does not run |
| memAddr | output | 16 | Memory address, zero when no access |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid one cycle after the address |
| regA | output | 8 | Accumulator |
| regX | output | 8 | X index register |
| regY | output | 8 | Y index register |
| regF | output | 8 | Flag byte |
| regSp | output | 8 | Stack pointer |
| regPc | output | 16 | Program counter |

## Verification
A stuck or wrong step counter shows up as `done` in the wrong cycle, and the bench sees that within three or four cycles of `start`. A wrong stack pointer step or ordering places the pushed byte in the wrong page-1 slot, or pulls the neighbouring byte. Either error appears at the memory port in the access cycle, and at `regSp` one cycle after `done`. A wrong register select or flag merge is visible on the register outputs in the cycle after `done`. That is where the scoreboard compares every register against its model.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;
  localparam int DATA_W = 8;
  localparam int PC_W   = 16;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = ADDR_W - DATA_W;
  localparam logic [PAGE_W-1:0] STACK_PAGE = PAGE_W'(1);

  localparam int PUSH_LEN  = 3;
  localparam int PULL_LEN  = 4;
  localparam int CNT_W     = $clog2(PULL_LEN + 1);
  localparam int XFER_STEP = 2;   // push writes, pull bumps SP
  localparam int READ_STEP = 3;   // pull presents read address
  localparam int LOAD_STEP = 4;   // pull captures read data

  localparam int FLAG_N_BIT = 7;
  localparam int FLAG_Z_BIT = 1;
  localparam logic [DATA_W-1:0] FLAG_FORCE = 8'h34;

  typedef enum logic [1:0] {SEL_A, SEL_F, SEL_X, SEL_Y} reg_sel_e;

  typedef struct packed {
    logic     memWrite;
    logic     memRead;
    logic     spDec;
    logic     spInc;
    logic     loadDst;
    logic     pcInc;
    reg_sel_e sel;
  } ctrl_strobe_t;
endpackage

// File: rtl/stack_xfer_ctrl.sv
module stack_xfer_ctrl
  import stack_xfer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [7:0]   opcode,
  output ctrl_strobe_t strobe,
  output logic         busy,
  output logic         done,
  output logic         unhandled
);
  logic             busyQ, pullQ, unhQ;
  reg_sel_e         selQ;
  logic [CNT_W-1:0] cntQ;

  logic     validOp, opPull;
  reg_sel_e opSel;
  logic     lastCycle;

  always_comb begin
    validOp = 1'b1;
    opPull  = 1'b0;
    opSel   = SEL_A;
    case (opcode)
      8'h48: begin opSel = SEL_A; opPull = 1'b0; end
      8'h08: begin opSel = SEL_F; opPull = 1'b0; end
      8'hDA: begin opSel = SEL_X; opPull = 1'b0; end
      8'h5A: begin opSel = SEL_Y; opPull = 1'b0; end
      8'h68: begin opSel = SEL_A; opPull = 1'b1; end
      8'h28: begin opSel = SEL_F; opPull = 1'b1; end
      8'hFA: begin opSel = SEL_X; opPull = 1'b1; end
      8'h7A: begin opSel = SEL_Y; opPull = 1'b1; end
      default: validOp = 1'b0;
    endcase
  end

  assign lastCycle = busyQ &&
    (cntQ == (pullQ ? CNT_W'(PULL_LEN) : CNT_W'(PUSH_LEN)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      pullQ <= 1'b0;
      selQ  <= SEL_A;
      cntQ  <= '0;
      unhQ  <= 1'b0;
    end else begin
      unhQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          if (validOp) begin
            busyQ <= 1'b1;
            cntQ  <= CNT_W'(1);
            pullQ <= opPull;
            selQ  <= opSel;
          end else begin
            unhQ <= 1'b1;
          end
        end
      end else if (lastCycle) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.memWrite = busyQ && !pullQ && (cntQ == CNT_W'(XFER_STEP));
    strobe.spDec    = busyQ && !pullQ && (cntQ == CNT_W'(XFER_STEP));
    strobe.spInc    = busyQ &&  pullQ && (cntQ == CNT_W'(XFER_STEP));
    strobe.memRead  = busyQ &&  pullQ && (cntQ == CNT_W'(READ_STEP));
    strobe.loadDst  = busyQ &&  pullQ && (cntQ == CNT_W'(LOAD_STEP));
    strobe.pcInc    = lastCycle;
    strobe.sel      = selQ;
  end

  assign busy      = busyQ;
  assign done      = lastCycle;
  assign unhandled = unhQ;
endmodule

// File: rtl/stack_xfer_dp.sv
module stack_xfer_dp
  import stack_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              preloadEn,
  input  logic [DATA_W-1:0] preloadA,
  input  logic [DATA_W-1:0] preloadX,
  input  logic [DATA_W-1:0] preloadY,
  input  logic [DATA_W-1:0] preloadF,
  input  logic [DATA_W-1:0] preloadSp,
  input  logic [PC_W-1:0]   preloadPc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regX,
  output logic [DATA_W-1:0] regY,
  output logic [DATA_W-1:0] regF,
  output logic [DATA_W-1:0] regSp,
  output logic [PC_W-1:0]   regPc
);
  logic [DATA_W-1:0] aQ, xQ, yQ, fQ, spQ;
  logic [PC_W-1:0]   pcQ;
  logic [DATA_W-1:0] pushData, mergedFlags;

  always_comb begin
    case (strobe.sel)
      SEL_A:   pushData = aQ;
      SEL_F:   pushData = fQ;
      SEL_X:   pushData = xQ;
      default: pushData = yQ;
    endcase
  end

  always_comb begin
    mergedFlags             = fQ;
    mergedFlags[FLAG_N_BIT] = memRdata[DATA_W-1];
    mergedFlags[FLAG_Z_BIT] = (memRdata == '0);
  end

  assign memAddr  = (strobe.memWrite || strobe.memRead) ? {STACK_PAGE, spQ} : '0;
  assign memWe    = strobe.memWrite;
  assign memWdata = strobe.memWrite ? pushData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aQ  <= '0;
      xQ  <= '0;
      yQ  <= '0;
      fQ  <= '0;
      spQ <= '1;
      pcQ <= '0;
    end else if (preloadEn) begin
      aQ  <= preloadA;
      xQ  <= preloadX;
      yQ  <= preloadY;
      fQ  <= preloadF;
      spQ <= preloadSp;
      pcQ <= preloadPc;
    end else begin
      if (strobe.spDec) spQ <= spQ - DATA_W'(1);
      if (strobe.spInc) spQ <= spQ + DATA_W'(1);
      if (strobe.pcInc) pcQ <= pcQ + PC_W'(1);
      if (strobe.loadDst) begin
        case (strobe.sel)
          SEL_A:   begin aQ <= memRdata; fQ <= mergedFlags; end
          SEL_X:   begin xQ <= memRdata; fQ <= mergedFlags; end
          SEL_Y:   begin yQ <= memRdata; fQ <= mergedFlags; end
          default: fQ <= memRdata | FLAG_FORCE;
        endcase
      end
    end
  end

  assign regA  = aQ;
  assign regX  = xQ;
  assign regY  = yQ;
  assign regF  = fQ;
  assign regSp = spQ;
  assign regPc = pcQ;
endmodule

// File: rtl/stack_xfer_unit.sv
module stack_xfer_unit
  import stack_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        preloadEn,
  input  logic [7:0]  preloadA,
  input  logic [7:0]  preloadX,
  input  logic [7:0]  preloadY,
  input  logic [7:0]  preloadF,
  input  logic [7:0]  preloadSp,
  input  logic [15:0] preloadPc,
  input  logic        start,
  input  logic [7:0]  opcode,
  output logic        busy,
  output logic        done,
  output logic        unhandled,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic [7:0]  regA,
  output logic [7:0]  regX,
  output logic [7:0]  regY,
  output logic [7:0]  regF,
  output logic [7:0]  regSp,
  output logic [15:0] regPc
);
  ctrl_strobe_t strobe;

  stack_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .strobe(strobe), .busy(busy), .done(done), .unhandled(unhandled)
  );

  stack_xfer_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .preloadEn(preloadEn), .preloadA(preloadA), .preloadX(preloadX),
    .preloadY(preloadY), .preloadF(preloadF), .preloadSp(preloadSp),
    .preloadPc(preloadPc), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .regA(regA), .regX(regX), .regY(regY), .regF(regF),
    .regSp(regSp), .regPc(regPc)
  );
endmodule

// File: rtl/stack_xfer_chk.sv
module stack_xfer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        preloadEn,
  input logic        busy,
  input logic        done,
  input logic        unhandled,
  input logic [15:0] memAddr,
  input logic        memWe,
  input logic [7:0]  regF,
  input logic [7:0]  regSp,
  input logic [15:0] regPc
);
  // R1: no activity directly out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!busy && !done && !unhandled && !memWe));

  // R2: every write lands in the stack page
  p_write_in_page_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[15:8] == 8'h01 && memAddr[7:0] == regSp));

  // R2 / R10: SP steps down (modulo 256) after a write
  p_sp_after_write_r10: assert property (@(posedge clk) disable iff (!rstN || preloadEn)
    memWe |=> (regSp == $past(regSp) - 8'd1));

  // R8: a write never touches the flags
  p_push_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rstN || preloadEn)
    memWe |=> $stable(regF));

  // R9: PC advances by one after done
  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rstN || preloadEn)
    done |=> (regPc == $past(regPc) + 16'd1));

  // R11: unhandled never overlaps execution and leaves PC alone
  p_unhandled_idle_r11: assert property (@(posedge clk) disable iff (!rstN || preloadEn)
    unhandled |-> (!busy && $stable(regPc)));

  // R3 / R5: done only inside an executing instruction
  p_done_in_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
endmodule

bind stack_xfer_unit stack_xfer_chk u_chk (
  .clk(clk), .rstN(rstN), .preloadEn(preloadEn), .busy(busy), .done(done),
  .unhandled(unhandled), .memAddr(memAddr), .memWe(memWe), .regF(regF),
  .regSp(regSp), .regPc(regPc)
);

// File: tb/stack_xfer_unit_test.sv
`timescale 1ns/100ps
module stack_xfer_unit_test;
  typedef struct {
    logic [7:0]  a, x, y, f, sp;
    logic [15:0] pc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        preloadEn = 1'b0;
  logic [7:0]  preloadA = '0, preloadX = '0, preloadY = '0, preloadF = '0, preloadSp = '0;
  logic [15:0] preloadPc = '0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        busy, done, unhandled, memWe;
  logic [15:0] memAddr, regPc;
  logic [7:0]  memWdata, memRdata, regA, regX, regY, regF, regSp;

  logic        tbWr = 1'b0;
  logic [7:0]  tbWrAddr = '0, tbWrData = '0;
  logic [7:0]  stk [256];

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  exp_t m;

  always #2.5 clk = ~clk;

  stack_xfer_unit uut (.*);

  // page-1 memory, read data registered one cycle after the address
  always @(posedge clk) begin
    if (tbWr) stk[tbWrAddr] <= tbWrData;
    else if (memWe && memAddr[15:8] == 8'h01) stk[memAddr[7:0]] <= memWdata;
    memRdata <= stk[memAddr[7:0]];
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic seed(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk); tbWr = 1'b1; tbWrAddr = addr; tbWrData = data;
    @(negedge clk); tbWr = 1'b0;
  endtask

  task automatic preload(input logic [7:0] a, x, y, f, sp, input logic [15:0] pc);
    @(negedge clk);
    preloadEn = 1'b1; preloadA = a; preloadX = x; preloadY = y;
    preloadF = f; preloadSp = sp; preloadPc = pc;
    @(negedge clk); preloadEn = 1'b0;
    m.a = a; m.x = x; m.y = y; m.f = f; m.sp = sp; m.pc = pc;
  endtask

  function automatic logic [7:0] flagMerge(input logic [7:0] f, input logic [7:0] b);
    logic [7:0] r = f;
    r[7] = b[7];
    r[1] = (b == 8'h00);
    return r;
  endfunction

  // driver: models the instruction, queues the expectation, runs it
  task automatic runOp(input logic [7:0] op, input bit poke, input string tag);
    exp_t e = m;
    bit isPush = 1'b0, valid = 1'b1;
    logic [7:0] wAddr = m.sp, wData = 8'h00, b;
    int expLen, n;
    e.tag = tag;
    b = stk[8'(m.sp + 8'd1)];
    case (op)
      8'h48: begin isPush = 1; wData = m.a; end
      8'h08: begin isPush = 1; wData = m.f; end
      8'hDA: begin isPush = 1; wData = m.x; end
      8'h5A: begin isPush = 1; wData = m.y; end
      8'h68: begin e.a = b; e.f = flagMerge(m.f, b); end
      8'hFA: begin e.x = b; e.f = flagMerge(m.f, b); end
      8'h7A: begin e.y = b; e.f = flagMerge(m.f, b); end
      8'h28: e.f = b | 8'h34;
      default: valid = 1'b0;
    endcase
    @(negedge clk); start = 1'b1; opcode = op;
    @(negedge clk); start = 1'b0;
    if (!valid) begin
      check(unhandled === 1'b1, tag, "R11 unhandled pulse", 16'(unhandled), 16'd1);
      check(busy === 1'b0, tag, "R11 busy stays low", 16'(busy), 16'd0);
      @(negedge clk);
      check(unhandled === 1'b0, tag, "R11 pulse width", 16'(unhandled), 16'd0);
      check(regPc === m.pc && regSp === m.sp && regA === m.a && regF === m.f,
            tag, "R11 state unchanged (pc)", regPc, m.pc);
      return;
    end
    if (isPush) e.sp = m.sp - 8'd1; else e.sp = m.sp + 8'd1;
    e.pc = m.pc + 16'd1;
    q.push_back(e);
    expLen = isPush ? 3 : 4;
    n = 1;
    if (poke) begin start = 1'b1; opcode = 8'h68; end
    while (done !== 1'b1 && n < 8) begin
      @(negedge clk); n++;
      if (n == 2) start = 1'b0;
      check(busy === 1'b1, tag, isPush ? "R3 busy held" : "R5 busy held", 16'(busy), 16'd1);
    end
    check(n == expLen, tag, isPush ? "R3 push length" : "R5 pull length",
          16'(n), 16'(expLen));
    if (isPush)
      check(stk[wAddr] === wData, tag, "R2 pushed byte at 0x0100+SP",
            {8'h00, stk[wAddr]}, {8'h00, wData});
    m = e;
    @(negedge clk);
    check(busy === 1'b0, tag, "busy drops after done", 16'(busy), 16'd0);
  endtask

  // monitor: compares the register file one cycle after done
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done === 1'b1) begin
        exp_t e;
        @(negedge clk);
        if (q.size() == 0) begin
          check(1'b0, "R9", "done without queued op", 16'd1, 16'd0);
        end else begin
          e = q.pop_front();
          check(regA  === e.a,  e.tag, "R9 regA",  {8'h0, regA},  {8'h0, e.a});
          check(regX  === e.x,  e.tag, "R9 regX",  {8'h0, regX},  {8'h0, e.x});
          check(regY  === e.y,  e.tag, "R9 regY",  {8'h0, regY},  {8'h0, e.y});
          check(regF  === e.f,  e.tag, "R6/R7/R8 regF", {8'h0, regF}, {8'h0, e.f});
          check(regSp === e.sp, e.tag, "R2/R4/R10 regSp", {8'h0, regSp}, {8'h0, e.sp});
          check(regPc === e.pc, e.tag, "R9 regPc", regPc, e.pc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m = '{a: 8'h0, x: 8'h0, y: 8'h0, f: 8'h0, sp: 8'hFF, pc: 16'h0, tag: ""};
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(regSp === 8'hFF, "R1", "regSp", {8'h0, regSp}, 16'h00FF);
    check(regA === 8'h0 && regX === 8'h0 && regY === 8'h0 && regF === 8'h0,
          "R1", "regA", {8'h0, regA}, 16'h0);
    check(regPc === 16'h0, "R1", "regPc", regPc, 16'h0);
    check(!busy && !done && !unhandled && !memWe, "R1", "control outputs",
          {12'h0, busy, done, unhandled, memWe}, 16'h0);

    // R2, R3, R8, R9: pushes of each register
    preload(8'hA7, 8'h03, 8'h04, 8'h55, 8'hFF, 16'h0200);
    runOp(8'h48, 1'b0, "R2 push A");
    preload(8'h02, 8'h03, 8'h04, 8'hC3, 8'hFE, 16'h0300);
    runOp(8'h08, 1'b0, "R8 push F");
    preload(8'h03, 8'h9E, 8'h05, 8'h53, 8'hFD, 16'h0400);
    runOp(8'hDA, 1'b0, "R2 push X");
    runOp(8'h5A, 1'b0, "R2 push Y");

    // R4, R5, R6: pulls into data registers
    seed(8'h81, 8'h00);
    preload(8'h11, 8'h03, 8'h04, 8'h82, 8'h80, 16'h0500);
    runOp(8'h68, 1'b0, "R6 pull A zero");
    seed(8'h81, 8'h9C);
    preload(8'h43, 8'h00, 8'h04, 8'h42, 8'h80, 16'h0600);
    runOp(8'hFA, 1'b0, "R6 pull X negative");
    seed(8'h82, 8'h41);
    runOp(8'h7A, 1'b0, "R4 pull Y positive");

    // R7: flag pulls
    seed(8'h81, 8'h00);
    preload(8'h02, 8'h03, 8'h04, 8'hFF, 8'h80, 16'h0700);
    runOp(8'h28, 1'b0, "R7 pull F zero");
    seed(8'h82, 8'hC1);
    runOp(8'h28, 1'b0, "R7 pull F C1");

    // R10: wrap both ways
    preload(8'h6B, 8'h01, 8'h02, 8'h10, 8'h00, 16'hFFFF);
    runOp(8'h48, 1'b0, "R10 push wrap");
    check(stk[8'h00] === 8'h6B, "R10", "byte at 0x0100", {8'h0, stk[8'h00]}, 16'h006B);
    seed(8'h00, 8'hE5);
    preload(8'h00, 8'h01, 8'h02, 8'h00, 8'hFF, 16'h0800);
    runOp(8'h68, 1'b0, "R10 pull wrap");

    // R11: unhandled opcodes
    preload(8'h12, 8'h34, 8'h56, 8'h78, 8'h90, 16'h0900);
    runOp(8'hEA, 1'b0, "R11 op EA");
    runOp(8'h49, 1'b0, "R11 op 49");

    // R12: start during busy is ignored
    seed(8'h91, 8'h77);
    preload(8'h3C, 8'h34, 8'h56, 8'h78, 8'h90, 16'h0A00);
    runOp(8'h48, 1'b1, "R12 start while busy");
    check(stk[8'h90] === 8'h3C, "R12", "pushed byte", {8'h0, stk[8'h90]}, 16'h003C);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9", "pending expectations", 16'(q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule